// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds eight token latches that two ports, called left and right, share. Software uses a token to claim a shared resource. A port reaches the bank through its own semaphore select, which replaces the memory chip select. Each access carries a latch index in the low address bits, one request/release data bit, a write strobe and an output enable. To claim a token, a port first writes a request. It then reads the latch back to learn whether it owns it.

A latch is free, held by the left port or held by the right port. It can never be held by both. A request that loses is stored as pending. When the holder releases, ownership moves to the waiting port on that same clock edge. If both ports request a free latch in the same cycle, the left port wins. The bank is fully synchronous. Each read returns its result one cycle later, with the result bit copied onto every data bit.

Top module: `sem_bank`

## Requirements
- R1: The latch index is address bits [2:0], so eight latches are addressed. All higher address bits are ignored.
- R2: A write takes effect only when the port's select is high and its write strobe is high. A read needs select high, output enable high and the write strobe low. The port's `rvalid` is high exactly one cycle after such a read and low in every other cycle.
- R3: A write whose data bit 0 is 0 is a request. A request to a free latch makes the writing port its holder.
- R4: A read returns all zeros to the holder. It returns all ones to the other port, and all ones to both ports when the latch is free. The value reflects the state before any write on the same clock edge.
- R5: A write whose data bit 0 is 1, made by the holder, frees the latch when no request is pending.
- R6: A release written by the port that does not hold the latch leaves the owner unchanged and withdraws that port's pending request.
- R7: A request to a latch held by the other port is remembered. When the holder releases, ownership passes to the waiting port on the same edge.
- R8: When both ports request a free latch in the same cycle, the left port gets it and the right port's request becomes pending.
- R9: A repeated request from the current holder does not change the latch.
- R10: After reset every latch is free, no request is pending and both `rvalid` outputs are low.
- R11: Latches are independent: an access to one index never changes another latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sem_sel | input | 1 | Left semaphore select |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | ADDR_W | Left address, index in [2:0] |
| l_wdata | input | DATA_W | Left write data, bit 0 used |
| l_rdata | output | DATA_W | Left read result |
| l_rvalid | output | 1 | Left read result valid |
| r_sem_sel | input | 1 | Right semaphore select |
| r_wr | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | ADDR_W | Right address, index in [2:0] |
| r_wdata | input | DATA_W | Right write data, bit 0 used |
| r_rdata | output | DATA_W | Right read result |
| r_rvalid | output | 1 | Right read result valid |

## Verification
A write changes a latch on the clock edge that samples it. A read issued in the next cycle therefore sees the new state. A read result and its `rvalid` appear one edge after the read is sampled. The driver puts the inputs up on the falling edge and pushes each read's expected word into a per-port queue. The monitor samples `rvalid` on the following falling edge, one full rising edge later. It pops the queue and compares. An `rvalid` with no matching entry, or an entry still queued at the end, counts as a failure of the timing rule.

// File: rtl/sem_pkg.sv
// Shared types for the semaphore token bank.
// Assumes: a latch is owned by at most one of two ports.
package sem_pkg;
    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_t;
endpackage

// File: rtl/sem_port_decode.sv
// Decodes one port's access into per-latch request and release strobes
// and a read strobe with its index.
// Assumes: index in the low address bits, request/release in data bit 0.
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 18,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               wr,
    input  logic               oe,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx
);
    logic [IDX_W-1:0] idx;
    logic             wr_en;

    // Pick the index and qualify the write strobe.
    always_comb begin
        idx    = addr[IDX_W-1:0];
        wr_en  = sel & wr;
        rd_en  = sel & oe & ~wr;
        rd_idx = idx;
    end

    // One request/release strobe per latch.
    for (genvar g = 0; g < NUM_SEM; g++) begin : g_strobe
        always_comb begin
            req_vec[g] = wr_en & (idx == IDX_W'(g)) & ~wdata[0];
            rel_vec[g] = wr_en & (idx == IDX_W'(g)) &  wdata[0];
        end
    end
endmodule

// File: rtl/sem_cell.sv
// One token latch with a pending-request bit for each port.
// Assumes: a port issues at most one of request/release per cycle;
// left wins a same-cycle tie; a waiting port inherits on release.
module sem_cell
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       l_req,
    input  logic       l_rel,
    input  logic       r_req,
    input  logic       r_rel,
    output sem_owner_t owner
);
    sem_owner_t nxt_owner;
    logic       l_pend, r_pend, nxt_lp, nxt_rp;

    // Next-state rules for ownership and pending requests.
    always_comb begin
        nxt_owner = owner;
        nxt_lp    = l_pend;
        nxt_rp    = r_pend;
        unique case (owner)
            OWN_FREE: begin
                nxt_lp = 1'b0;
                nxt_rp = 1'b0;
                if (l_req) begin
                    nxt_owner = OWN_LEFT;
                    nxt_rp    = r_req;
                end else if (r_req) begin
                    nxt_owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nxt_lp = 1'b0;
                if (l_rel) begin
                    nxt_owner = (r_req || (r_pend && !r_rel)) ? OWN_RIGHT : OWN_FREE;
                    nxt_rp    = 1'b0;
                end else if (r_req) begin
                    nxt_rp = 1'b1;
                end else if (r_rel) begin
                    nxt_rp = 1'b0;
                end
            end
            OWN_RIGHT: begin
                nxt_rp = 1'b0;
                if (r_rel) begin
                    nxt_owner = (l_req || (l_pend && !l_rel)) ? OWN_LEFT : OWN_FREE;
                    nxt_lp    = 1'b0;
                end else if (l_req) begin
                    nxt_lp = 1'b1;
                end else if (l_rel) begin
                    nxt_lp = 1'b0;
                end
            end
            default: begin
                nxt_owner = OWN_FREE;
                nxt_lp    = 1'b0;
                nxt_rp    = 1'b0;
            end
        endcase
    end

    // State registers with synchronous reset to free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner  <= OWN_FREE;
            l_pend <= 1'b0;
            r_pend <= 1'b0;
        end else begin
            owner  <= nxt_owner;
            l_pend <= nxt_lp;
            r_pend <= nxt_rp;
        end
    end

    assert_pend_owned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_pend |-> owner == OWN_RIGHT) and (r_pend |-> owner == OWN_LEFT));
    assert_free_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_FREE && r_req && !l_req) |=> owner == OWN_RIGHT);
    assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_FREE && l_req && r_req) |=> (owner == OWN_LEFT && r_pend));
    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && l_rel && r_pend && !r_rel) |=> owner == OWN_RIGHT);
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_RIGHT && r_rel && !l_pend && !l_req) |=> owner == OWN_FREE);
    assert_foreign_rel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && r_rel && !l_rel) |=> (owner == OWN_LEFT && !r_pend));
    assert_rerequest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_LEFT && l_req && !r_req && !r_rel) |=> $stable(owner));
endmodule

// File: rtl/sem_read_port.sv
// Registered read path for one port: returns 0 on all bits to the holder,
// 1 on all bits otherwise, one cycle after the read.
// Assumes: SIDE is the owner code that means "this port holds it".
module sem_read_port
    import sem_pkg::*;
#(
    parameter int         NUM_SEM = 8,
    parameter int         DATA_W  = 18,
    parameter sem_owner_t SIDE    = OWN_LEFT,
    localparam int        IDX_W   = $clog2(NUM_SEM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_idx,
    input  sem_owner_t [NUM_SEM-1:0] owners,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid
);
    logic not_mine;

    // Status bit of the addressed latch from this port's view.
    always_comb not_mine = (owners[rd_idx] != SIDE);

    // Capture the result on a read; valid pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '1;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= {DATA_W{not_mine}};
        end
    end

    assert_valid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    assert_valid_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    assert_copied_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rdata == '0 || rdata == '1));
endmodule

// File: rtl/sem_bank.sv
// Top of the two-port semaphore token bank: a decoder per port, one cell
// per latch, and a registered read path per port.
// Assumes: both ports share clk; reset is synchronous active-low.
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_sem_sel,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);
    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0]       l_req, l_rel, r_req, r_rel;
    logic                     l_rd, r_rd;
    logic [IDX_W-1:0]         l_ridx, r_ridx;
    sem_owner_t [NUM_SEM-1:0] owners;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(l_sem_sel), .wr(l_wr), .oe(l_oe), .addr(l_addr), .wdata(l_wdata),
        .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd), .rd_idx(l_ridx));

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(r_sem_sel), .wr(r_wr), .oe(r_oe), .addr(r_addr), .wdata(r_wdata),
        .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd), .rd_idx(r_ridx));

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .owner(owners[g]));
    end

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .SIDE(OWN_LEFT)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .rd_idx(l_ridx),
        .owners(owners), .rdata(l_rdata), .rvalid(l_rvalid));

    sem_read_port #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .SIDE(OWN_RIGHT)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .rd_idx(r_ridx),
        .owners(owners), .rdata(r_rdata), .rvalid(r_rvalid));

    // Both ports never both see "held" for the same latch in one cycle.
    assert_single_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rvalid && r_rvalid && l_rdata == '0 && r_rdata == '0)
        |-> ($past(l_addr[IDX_W-1:0]) != $past(r_addr[IDX_W-1:0])));
    // A deselected port produces no read result.
    assert_no_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_sem_sel && !r_sem_sel) |=> (!l_rvalid && !r_rvalid));
endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 18;
    localparam int K_NONE = 0, K_WR = 1, K_RD = 2, K_WR_NOSEL = 3,
                   K_RD_NOOE = 4, K_RD_NOSEL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sem_sel = 0, l_wr = 0, l_oe = 0;
    logic r_sem_sel = 0, r_wr = 0, r_oe = 0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic [DATA_W-1:0] l_rdata, r_rdata;
    logic l_rvalid, r_rvalid;

    int n_total = 0, n_fail = 0;
    bit done = 0;
    bit exp_lq[$], exp_rq[$];
    string tag_lq[$], tag_rq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank #(.NUM_SEM(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_sem_sel(r_sem_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic drive_side(input bit right, input int k,
                              input logic [ADDR_W-1:0] a, input logic b);
        logic s, w, o;
        logic [DATA_W-1:0] d;
        s = (k == K_WR || k == K_RD || k == K_RD_NOOE);
        w = (k == K_WR || k == K_WR_NOSEL);
        o = (k == K_RD || k == K_RD_NOSEL);
        d = {{(DATA_W-1){~b}}, b};
        if (right) begin
            r_sem_sel = s; r_wr = w; r_oe = o; r_addr = a; r_wdata = d;
        end else begin
            l_sem_sel = s; l_wr = w; l_oe = o; l_addr = a; l_wdata = d;
        end
    endtask

    // Driver: one cycle of stimulus on both ports; reads queue expectations.
    task automatic step(input int lk, input logic [ADDR_W-1:0] la, input logic lb,
                        input int rk, input logic [ADDR_W-1:0] ra, input logic rb,
                        input string tag);
        drive_side(0, lk, la, lb);
        drive_side(1, rk, ra, rb);
        if (lk == K_RD) begin exp_lq.push_back(lb); tag_lq.push_back(tag); end
        if (rk == K_RD) begin exp_rq.push_back(rb); tag_rq.push_back(tag); end
        @(negedge clk);
        drive_side(0, K_NONE, '0, 1'b0);
        drive_side(1, K_NONE, '0, 1'b0);
    endtask

    // Read both ports at one index, with the expected status bit for each.
    task automatic rd_both(input logic [ADDR_W-1:0] a, input bit le, input bit re,
                           input string tag);
        step(K_RD, a, le, K_RD, a, re, tag);
    endtask

    // Monitor: pop and compare whenever a result is presented.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (l_rvalid) begin
                if (exp_lq.size() == 0) check(0, "R2", "left unexpected rvalid", l_rdata, '0);
                else begin
                    bit e; string t;
                    e = exp_lq.pop_front(); t = tag_lq.pop_front();
                    check(l_rdata == {DATA_W{e}}, t, "left read", l_rdata, {DATA_W{e}});
                end
            end
            if (r_rvalid) begin
                if (exp_rq.size() == 0) check(0, "R2", "right unexpected rvalid", r_rdata, '0);
                else begin
                    bit e; string t;
                    e = exp_rq.pop_front(); t = tag_rq.pop_front();
                    check(r_rdata == {DATA_W{e}}, t, "right read", r_rdata, {DATA_W{e}});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset leaves no valid output.
        check(!l_rvalid && !r_rvalid, "R10", "rvalid after reset",
              {l_rvalid, r_rvalid}, '0);
        // R10: every latch free.
        for (int i = 0; i < 8; i++) rd_both(ADDR_W'(i), 1, 1, "R10");

        // R3/R4/R11: left claims 2; 3 untouched.
        step(K_WR, 2, 0, K_NONE, 0, 0, "R3");
        rd_both(2, 0, 1, "R3");
        rd_both(3, 1, 1, "R11");
        // R7: right waits on 2, still not owner.
        step(K_NONE, 0, 0, K_WR, 2, 0, "R7");
        rd_both(2, 0, 1, "R7");
        // R7: left release hands it to right.
        step(K_WR, 2, 1, K_NONE, 0, 0, "R7");
        rd_both(2, 1, 0, "R7");
        // R5: holder release frees it.
        step(K_NONE, 0, 0, K_WR, 2, 1, "R5");
        rd_both(2, 1, 1, "R5");

        // R8: tie on free latch 5, left wins, right inherits.
        step(K_WR, 5, 0, K_WR, 5, 0, "R8");
        rd_both(5, 0, 1, "R8");
        step(K_WR, 5, 1, K_NONE, 0, 0, "R8");
        rd_both(5, 1, 0, "R8");
        step(K_NONE, 0, 0, K_WR, 5, 1, "R5");

        // R6: non-holder release has no effect and withdraws its wait.
        step(K_WR, 1, 0, K_NONE, 0, 0, "R6");
        step(K_NONE, 0, 0, K_WR, 1, 1, "R6");
        rd_both(1, 0, 1, "R6");
        step(K_NONE, 0, 0, K_WR, 1, 0, "R6");
        step(K_NONE, 0, 0, K_WR, 1, 1, "R6");
        step(K_WR, 1, 1, K_NONE, 0, 0, "R6");
        rd_both(1, 1, 1, "R6");

        // R1: high address bits ignored (16'h7FFC -> index 4).
        step(K_WR, 16'h7FFC, 0, K_NONE, 0, 0, "R1");
        rd_both(16'h0004, 0, 1, "R1");
        rd_both(16'hA5A4, 0, 1, "R1");
        // R9: repeated request by holder changes nothing.
        step(K_WR, 4, 0, K_NONE, 0, 0, "R9");
        rd_both(4, 0, 1, "R9");
        step(K_WR, 4, 1, K_NONE, 0, 0, "R5");
        rd_both(4, 1, 1, "R5");

        // R2: deselected write and gated reads do nothing.
        step(K_NONE, 0, 0, K_WR_NOSEL, 6, 0, "R2");
        step(K_RD_NOOE, 6, 0, K_RD_NOSEL, 6, 0, "R2");
        step(K_NONE, 0, 0, K_NONE, 0, 0, "R2");
        rd_both(6, 1, 1, "R2");

        // R4: read sees state before a same-edge write.
        step(K_RD, 7, 1, K_WR, 7, 0, "R4");
        rd_both(7, 1, 0, "R4");

        repeat (3) @(negedge clk);
        check(exp_lq.size() == 0 && exp_rq.size() == 0, "R2", "results still owed",
              DATA_W'(exp_lq.size() + exp_rq.size()), '0);
        finish_run();
    end
endmodule